// File: doc/BRIEF.md
# ADC Port Owner Switch

This block sits between one external serial ADC and two on-chip SPI masters. One master is driven by host registers and the other belongs to a control loop. A 3-bit owner code picks which master drives the converter's serial clock, data-out and conversion-start pins. Serial data from the converter goes back only to the master that owns the port. The master that does not own the port sees a constant 0.

A third setting is a flush mode. It gives the port to the host master but holds the conversion-start pin low. The host master can then run serial clocks into a converter that has lost word alignment without starting a new conversion. Every code other than the host code and the loop code acts as flush.

The block also holds the host receive buffer. It shifts in the bits seen on the host's data input at each rising host clock edge. On the host's done pulse it loads the buffer, but only if the whole transfer ran under the host code. Transfers run by the control loop, flush transfers and transfers done without owning the port leave the buffer unchanged.

Top module: `adc_port_switch`

## Requirements
- R1: With owner code 0, `port_sck` and `port_mosi` follow `host_sck` and `host_mosi`. `port_conv` equals the inverse of `host_cs_n`, and `host_miso` equals `port_miso`.
- R2: With owner code 2 (flush), `port_sck` and `port_mosi` follow the host master. `port_conv` is held at 0 and `host_miso` is 0.
- R3: With owner code 4, `port_sck` and `port_mosi` follow `loop_sck` and `loop_mosi`. `port_conv` equals the inverse of `loop_cs_n`, and `loop_miso` equals `port_miso`.
- R4: Owner codes 1, 3, 5, 6 and 7 behave exactly like code 2.
- R5: `loop_miso` is 0 under every code except 4, and `host_miso` is 0 under every code except 0.
- R6: A host transfer runs from a falling `host_cs_n` to a one-cycle `host_done` pulse. If the code is 0 for the whole transfer, `host_rx` holds the last RX_W bits sampled at rising `host_sck` edges while `host_cs_n` is low. The first bit sampled ends up in the MSB. `host_rx` updates one clock after `host_done`.
- R7: If the owner code is not 0 in any cycle of a host transfer, the `host_done` pulse leaves `host_rx` unchanged.
- R8: `host_rx` changes only in the cycle after a `host_done` pulse. Control-loop transfers do not change it.
- R9: After reset, `host_rx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with both masters |
| rst_n | input | 1 | Active-low synchronous reset |
| owner | input | 3 | Owner code: 0 host, 4 loop, other codes flush |
| host_sck | input | 1 | Host master serial clock |
| host_mosi | input | 1 | Host master serial data out |
| host_cs_n | input | 1 | Host master select, active low |
| host_done | input | 1 | One-cycle end-of-transfer pulse from the host master |
| host_miso | output | 1 | Serial data returned to the host master |
| host_rx | output | RX_W | Host receive buffer |
| loop_sck | input | 1 | Loop master serial clock |
| loop_mosi | input | 1 | Loop master serial data out |
| loop_cs_n | input | 1 | Loop master select, active low |
| loop_miso | output | 1 | Serial data returned to the loop master |
| port_sck | output | 1 | Converter serial clock |
| port_mosi | output | 1 | Converter serial data in |
| port_conv | output | 1 | Converter conversion start, active high |
| port_miso | input | 1 | Converter serial data out |

## Verification
The pin routing has no state, so a wrong decode shows up in the same cycle as a wrong level on `port_conv` or a wrong owner on the clock or data pins. The likely internal faults are a stale capture-valid flag or a misaligned shift register. These show up only at the next `host_done`, one clock later, as a buffer that moved when it should have held, or a word that is shifted or bit-reversed. The bench therefore runs whole host transfers under the host code, under flush codes, under the loop code and with a code change partway through. Each transfer is compared against a word predicted from the bits it drove.

// File: rtl/adc_port_switch.sv
module adc_port_switch #(
  parameter int RX_W = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      owner,
  input  logic            host_sck,
  input  logic            host_mosi,
  input  logic            host_cs_n,
  input  logic            host_done,
  output logic            host_miso,
  output logic [RX_W-1:0] host_rx,
  input  logic            loop_sck,
  input  logic            loop_mosi,
  input  logic            loop_cs_n,
  output logic            loop_miso,
  output logic            port_sck,
  output logic            port_mosi,
  output logic            port_conv,
  input  logic            port_miso
);
  localparam logic [2:0] OWN_HOST = 3'd0;
  localparam logic [2:0] OWN_LOOP = 3'd4;

  logic loop_mode, host_mode, flush_mode;
  assign loop_mode  = (owner == OWN_LOOP);
  assign host_mode  = (owner == OWN_HOST);
  assign flush_mode = !loop_mode && !host_mode;

  assign port_sck  = loop_mode ? loop_sck  : host_sck;
  assign port_mosi = loop_mode ? loop_mosi : host_mosi;
  assign port_conv = loop_mode ? ~loop_cs_n : (host_mode & ~host_cs_n);
  assign host_miso = host_mode & port_miso;
  assign loop_miso = loop_mode & port_miso;

  logic            sck_q, cs_q, cap_ok;
  logic [RX_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      cap_ok  <= 1'b0;
      shreg   <= '0;
      host_rx <= '0;
    end else begin
      sck_q <= host_sck;
      cs_q  <= host_cs_n;
      if (cs_q && !host_cs_n)
        cap_ok <= host_mode;
      else if (!host_mode)
        cap_ok <= 1'b0;
      if (!host_cs_n && host_sck && !sck_q)
        shreg <= {shreg[RX_W-2:0], host_miso};
      if (host_done && cap_ok)
        host_rx <= shreg;
    end
  end

  assert_flush_conv_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flush_mode |-> !port_conv && !host_miso);
  assert_unlisted_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == 3'd7) |-> (port_sck == host_sck) && !port_conv);
  assert_loop_owns_R3: assert property (@(posedge clk) disable iff (!rst_n)
    loop_mode |-> (port_conv == !loop_cs_n) && !host_miso);
  assert_host_owns_R1: assert property (@(posedge clk) disable iff (!rst_n)
    host_mode |-> (port_conv == !host_cs_n) && !loop_miso);
  assert_rx_only_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !host_done |=> $stable(host_rx));
  assert_rx_hold_foreign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_done && !cap_ok) |=> $stable(host_rx));
endmodule

// File: tb/test_adc_port_switch.sv
module test_adc_port_switch;
  localparam int RX_W = 18;
  logic clk = 0, rst_n = 0;
  logic [2:0] owner = 0;
  logic host_sck = 0, host_mosi = 0, host_cs_n = 1, host_done = 0;
  logic loop_sck = 0, loop_mosi = 0, loop_cs_n = 1, port_miso = 0;
  logic host_miso, loop_miso, port_sck, port_mosi, port_conv;
  logic [RX_W-1:0] host_rx;
  int n_run = 0, n_fail = 0;
  logic [RX_W-1:0] exp_rx = '0;

  always #5 clk = ~clk;

  adc_port_switch #(.RX_W(RX_W)) i_adc_port_switch (
    .clk, .rst_n, .owner, .host_sck, .host_mosi, .host_cs_n, .host_done,
    .host_miso, .host_rx, .loop_sck, .loop_mosi, .loop_cs_n, .loop_miso,
    .port_sck, .port_mosi, .port_conv, .port_miso);

  function automatic logic [4:0] model(input logic [2:0] o);
    logic lp = (o == 3'd4), hs = (o == 3'd0);
    logic [4:0] r;
    r[4] = lp ? loop_sck : host_sck;
    r[3] = lp ? loop_mosi : host_mosi;
    r[2] = lp ? !loop_cs_n : (hs && !host_cs_n);
    r[1] = hs && port_miso;
    r[0] = lp && port_miso;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic pins_check(input string req);
    #2;
    check(req, {27'd0, port_sck, port_mosi, port_conv, host_miso, loop_miso},
          {27'd0, model(owner)});
  endtask

  task automatic host_xfer(input logic [RX_W-1:0] w, input logic [2:0] code,
                           input int glitch_bit, input logic [2:0] glitch_code);
    logic ok = (code == 3'd0) && (glitch_bit < 0 || glitch_code == 3'd0);
    owner = code; tick();
    host_cs_n = 0; tick();
    for (int i = RX_W - 1; i >= 0; i--) begin
      if (RX_W - 1 - i == glitch_bit) owner = glitch_code;
      port_miso = w[i]; host_mosi = $urandom; host_sck = 1; tick();
      owner = code;
      host_sck = 0; tick();
    end
    host_cs_n = 1; tick();
    host_done = 1; tick();
    host_done = 0;
    if (ok) exp_rx = w;
    #2;
    if (ok) check("R6 capture", {14'd0, host_rx}, {14'd0, exp_rx});
    else if (glitch_bit >= 0) check("R7 mid-transfer switch", {14'd0, host_rx}, {14'd0, exp_rx});
    else check("R7 non-owner transfer", {14'd0, host_rx}, {14'd0, exp_rx});
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_run++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    tick(); tick(); rst_n = 1; #2;
    check("R9 reset", {14'd0, host_rx}, 32'd0);
    owner = 0; host_cs_n = 0; port_miso = 1; pins_check("R1 host conv");
    owner = 2; pins_check("R2 flush conv low");
    owner = 4; loop_cs_n = 0; pins_check("R3 loop conv");
    for (int c = 0; c < 8; c++) begin owner = c[2:0]; pins_check("R4/R5 code sweep"); end
    for (int k = 0; k < 300; k++) begin
      tick();
      owner = $urandom; host_sck = $urandom; host_mosi = $urandom; host_cs_n = $urandom;
      loop_sck = $urandom; loop_mosi = $urandom; loop_cs_n = $urandom; port_miso = $urandom;
      if (owner == 0) pins_check("R1 random");
      else if (owner == 4) pins_check("R3 random");
      else pins_check("R2/R4 random");
      if (owner != 0) check("R5 host miso zero", {31'd0, host_miso}, 32'd0);
      if (owner != 4) check("R5 loop miso zero", {31'd0, loop_miso}, 32'd0);
    end
    #2; check("R8 no done no change", {14'd0, host_rx}, {14'd0, exp_rx});
    host_sck = 0; host_cs_n = 1; loop_cs_n = 1; tick();
    host_xfer(18'h2A5C3, 3'd0, -1, 3'd0);
    host_xfer(18'h3FFFF, 3'd0, -1, 3'd0);
    host_xfer(18'h20001, 3'd0, -1, 3'd0);
    host_xfer(18'h15555, 3'd2, -1, 3'd0);
    host_xfer(18'h0F0F0, 3'd6, -1, 3'd0);
    host_xfer(18'h12345, 3'd4, -1, 3'd0);
    host_xfer(18'h0ABCD, 3'd0, 7, 3'd2);
    host_xfer(18'h0ABCD, 3'd0, 0, 3'd4);
    owner = 4; tick();
    loop_cs_n = 0;
    for (int i = 0; i < RX_W; i++) begin
      port_miso = $urandom; loop_sck = 1; tick(); loop_sck = 0; tick();
    end
    loop_cs_n = 1; tick(); #2;
    check("R8 loop transfer", {14'd0, host_rx}, {14'd0, exp_rx});
    for (int k = 0; k < 40; k++) begin
      logic [2:0] c = ($urandom % 3 == 0) ? 3'($urandom) : 3'd0;
      host_xfer(18'($urandom), c, -1, 3'd0);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule